// File: doc/BRIEF.md
# Configurable-Width ROM Read Port

This block is a clock-accurate, synthesizable model of the read side of a one-time-programmable memory. A system bus presents an address, an active-low chip enable and an active-low output enable. The block drives a 16-bit data bus with a separate output-enable bit for each lane, so a wrapper can build real tri-state pads from it. A width-select input picks the organisation. In word mode the full 16-bit word is returned. In byte mode the top pin turns into the lowest address bit and picks one byte of the addressed word, which appears on the lower eight lanes.

Access timing is counted in clock cycles. Any change to the address or the organisation, and any fall of chip enable, starts a long access wait. A fall of output enable starts only a short wait. An explicit valid flag goes with the data. While that flag is low, the data lanes carry zeros instead of stale values. An identification mode replaces array contents with two fixed codes. The storage is a small register array that comes up blank (all ones) and is filled through a preload port used by test.

Top module: `cfg_rom_rdport`

## Requirements
- R1: In word mode (`wide_sel`=1) with valid data, all 16 lane enables are 1 and `dq_out` equals the addressed word, with bit 15 on lane 15.
- R2: In byte mode (`wide_sel`=0), `lsb_in`=0 selects bits 7:0 of the addressed word and `lsb_in`=1 selects bits 15:8. The byte appears on lanes 7:0. Lane enables 15:8 are 0 and `dq_out[15:8]` is 0.
- R3: While `ce_n` or `oe_n` is 1, every lane enable is 0 and `data_valid` is 0, whatever the other inputs are.
- R4: After reset every array word reads 16'hFFFF.
- R5: While `id_mode`=1, lanes 7:0 carry 8'h20 when `addr[0]`=0 and 8'h32 when `addr[0]`=1. The higher address bits are ignored, and in word mode lanes 15:8 read 0.
- R6: A change of `addr`, `wide_sel` or `id_mode`, a change of `lsb_in` while in byte mode, or `ce_n` going low keeps `data_valid` at 0 until ACC_CYC+1 rising edges have sampled the new value (ACC_CYC=4 by default).
- R7: A fall of `oe_n` with nothing else changing keeps `data_valid` at 0 until OE_CYC+1 rising edges have sampled it (OE_CYC=2 by default). It does not restart the long wait.
- R8: While `data_valid` is 0, `dq_out` is all zeros.
- R9: In word mode a change of `lsb_in` neither changes `dq_out` nor clears `data_valid`.
- R10: A preload write (`pl_we`=1 at a rising edge) stores `pl_data` at `pl_addr`, and a later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wide_sel | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| lsb_in | input | 1 | Byte-select address bit, used in byte mode only |
| id_mode | input | 1 | Identifier readout mode |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | ADDR_W | Preload address |
| pl_data | input | 16 | Preload data |
| dq_out | output | 16 | Data lanes |
| dq_oe | output | 16 | Per-lane output enable |
| data_valid | output | 1 | Access latency has elapsed and data is good |

## Verification
The assertions assume that the inputs change only between rising edges and stay stable across each edge, and that reset is held long enough for the array to be cleared. They also assume preloads take place while the port is deselected, so that array contents never change under a read in progress. The stimulus drives every input on the falling clock edge. Preloads are done with `ce_n` high before any random traffic starts. The random mix of address, enable, width, byte-select and identification changes is biased toward the selected state, so that both latency windows are crossed often.

// File: rtl/rom_rd_pkg.sv
// Shared constants and read-view type for the configurable-width ROM read port.
// Assumes a 16-bit array word split into two 8-bit lanes groups.
package rom_rd_pkg;
    localparam int DQ_W   = 16;
    localparam int LANE_W = 8;
    localparam int GROUPS = DQ_W / LANE_W;
    localparam logic [DQ_W-1:0] BLANK_WORD = {DQ_W{1'b1}};

    typedef enum logic [1:0] {
        VIEW_WORD  = 2'd0,
        VIEW_LOW   = 2'd1,
        VIEW_HIGH  = 2'd2,
        VIEW_IDENT = 2'd3
    } view_e;

    // Choose which value the lanes present; identification overrides width.
    function automatic view_e pick_view(input logic ident, input logic wide, input logic lsb);
        if (ident)     return VIEW_IDENT;
        else if (wide) return VIEW_WORD;
        else if (lsb)  return VIEW_HIGH;
        else           return VIEW_LOW;
    endfunction
endpackage

// File: rtl/rom_cell_array.sv
// Small register array holding the memory contents.
// Clears to all ones on reset (blank part) and accepts one preload write per cycle.
// Read is combinational from the stored registers.
module rom_cell_array
    import rom_rd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DQ_W-1:0]   rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DQ_W-1:0] cells [DEPTH];

    // Blank the array on reset, otherwise apply a preload write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= BLANK_WORD;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Present the addressed word.
    always_comb begin
        rd_word = cells[rd_addr];
    end
endmodule

// File: rtl/rom_change_detect.sv
// Registers the read-side inputs and flags which latency window each change restarts.
// Assumes inputs are stable across the rising edge. The byte-select bit counts
// only in byte mode. Deselection holds the matching window in restart.
module rom_change_detect #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wide_sel,
    input  logic              lsb_in,
    input  logic              id_mode,
    output logic              full_restart,
    output logic              short_restart
);
    logic [ADDR_W-1:0] addr_q;
    logic              ce_q;
    logic              oe_q;
    logic              wide_q;
    logic              lsb_q;
    logic              id_q;
    logic              lsb_moved;

    // Remember the inputs seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            ce_q   <= 1'b1;
            oe_q   <= 1'b1;
            wide_q <= 1'b1;
            lsb_q  <= 1'b0;
            id_q   <= 1'b0;
        end else begin
            addr_q <= addr;
            ce_q   <= ce_n;
            oe_q   <= oe_n;
            wide_q <= wide_sel;
            lsb_q  <= lsb_in;
            id_q   <= id_mode;
        end
    end

    // Classify input movement into long-window and short-window restarts.
    always_comb begin
        lsb_moved     = !wide_sel && (lsb_in != lsb_q);
        full_restart  = ce_n || (ce_n != ce_q) || (addr != addr_q) ||
                        (wide_sel != wide_q) || (id_mode != id_q) || lsb_moved;
        short_restart = oe_n || (oe_n != oe_q);
    end
endmodule

// File: rtl/rom_lat_counter.sv
// Count-down timer for one access window.
// Loads CYC on restart, counts to zero and reports done only when no restart is pending.
// Assumes CYC >= 1.
module rom_lat_counter #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int CNT_W = $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC);

    logic [CNT_W-1:0] remain;

    // Reload on restart, otherwise run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= LOAD;
        end else if (restart) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Elapsed once the count is spent and the inputs are settled.
    always_comb begin
        done = (remain == '0) && !restart;
    end
endmodule

// File: rtl/rom_lane_mux.sv
// Forms the data lanes and per-lane enables from the array word and the read view.
// Assumes the valid flag already folds in selection. Data is zero until valid.
module rom_lane_mux
    import rom_rd_pkg::*;
#(
    parameter logic [LANE_W-1:0] MFR_ID = 8'h20,
    parameter logic [LANE_W-1:0] DEV_ID = 8'h32
) (
    input  logic [DQ_W-1:0] rd_word,
    input  logic            id_mode,
    input  logic            addr0,
    input  logic            wide_sel,
    input  logic            lsb_in,
    input  logic            selected,
    input  logic            valid,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe
);
    view_e           view;
    logic [DQ_W-1:0] shaped;
    logic [GROUPS-1:0] grp_en;

    // Pick the value the lanes carry for this view.
    always_comb begin
        view = pick_view(id_mode, wide_sel, lsb_in);
        unique case (view)
            VIEW_WORD:  shaped = rd_word;
            VIEW_LOW:   shaped = {{LANE_W{1'b0}}, rd_word[LANE_W-1:0]};
            VIEW_HIGH:  shaped = {{LANE_W{1'b0}}, rd_word[DQ_W-1:LANE_W]};
            default:    shaped = {{LANE_W{1'b0}}, (addr0 ? DEV_ID : MFR_ID)};
        endcase
        dq_out = valid ? shaped : '0;
    end

    // Enable each lane group: group 0 whenever selected, upper groups in word mode only.
    for (genvar g = 0; g < GROUPS; g++) begin : g_lane_grp
        if (g == 0) begin : g_low
            assign grp_en[g] = selected;
        end else begin : g_up
            assign grp_en[g] = selected && wide_sel;
        end
        assign dq_oe[g*LANE_W +: LANE_W] = {LANE_W{grp_en[g]}};
    end
endmodule

// File: rtl/cfg_rom_rdport.sv
// Top of the configurable-width ROM read port.
// Word or byte organisation, standby, output disable and identifier readout,
// with long and short access windows counted in clock cycles.
// Assumes inputs change between rising edges and preloads happen while deselected.
module cfg_rom_rdport
    import rom_rd_pkg::*;
#(
    parameter int                ADDR_W  = 6,
    parameter int                ACC_CYC = 4,
    parameter int                OE_CYC  = 2,
    parameter logic [7:0]        MFR_ID  = 8'h20,
    parameter logic [7:0]        DEV_ID  = 8'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wide_sel,
    input  logic              lsb_in,
    input  logic              id_mode,
    input  logic              pl_we,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [15:0]       pl_data,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic              data_valid
);
    logic [DQ_W-1:0] rd_word;
    logic            full_restart;
    logic            short_restart;
    logic            full_done;
    logic            short_done;
    logic            selected;

    rom_cell_array #(.ADDR_W(ADDR_W)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pl_we),
        .wr_addr (pl_addr),
        .wr_data (pl_data),
        .rd_addr (addr),
        .rd_word (rd_word)
    );

    rom_change_detect #(.ADDR_W(ADDR_W)) chg_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (addr),
        .ce_n          (ce_n),
        .oe_n          (oe_n),
        .wide_sel      (wide_sel),
        .lsb_in        (lsb_in),
        .id_mode       (id_mode),
        .full_restart  (full_restart),
        .short_restart (short_restart)
    );

    rom_lat_counter #(.CYC(ACC_CYC)) acc_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (full_restart),
        .done    (full_done)
    );

    rom_lat_counter #(.CYC(OE_CYC)) oe_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (short_restart),
        .done    (short_done)
    );

    // Selection and validity: both enables low and both windows spent.
    always_comb begin
        selected   = !ce_n && !oe_n;
        data_valid = selected && full_done && short_done;
    end

    rom_lane_mux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) mux_i (
        .rd_word  (rd_word),
        .id_mode  (id_mode),
        .addr0    (addr[0]),
        .wide_sel (wide_sel),
        .lsb_in   (lsb_in),
        .selected (selected),
        .valid    (data_valid),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );
endmodule

// File: rtl/rom_rdport_chk.sv
// Port-level property checker for cfg_rom_rdport, attached by bind.
// Assumes inputs are stable across each rising edge.
module rom_rdport_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              wide_sel,
    input logic              lsb_in,
    input logic              id_mode,
    input logic [15:0]       dq_out,
    input logic [15:0]       dq_oe,
    input logic              data_valid
);
    a_r3_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (dq_oe == 16'h0000 && !data_valid));

    a_r2_upper_lanes_off_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_sel |-> (dq_oe[15:8] == 8'h00 && dq_out[15:8] == 8'h00));

    a_r1_all_lanes_on_word: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && wide_sel) |-> (dq_oe == 16'hFFFF));

    a_r8_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> (dq_out == 16'h0000));

    a_r6_addr_move_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != $past(addr)) |-> !data_valid);

    a_r6_ce_fall_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> !data_valid);

    a_r7_oe_fall_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !data_valid);

    a_r5_ident_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && id_mode) |-> (dq_out[15:8] == 8'h00 &&
                                     (dq_out[7:0] == 8'h20 || dq_out[7:0] == 8'h32)));

    a_r9_lsb_ignored_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_sel && $past(wide_sel) && $past(data_valid) && $stable(addr) &&
         $stable(ce_n) && $stable(oe_n) && $stable(id_mode)) |-> (data_valid && $stable(dq_out)));
endmodule

bind cfg_rom_rdport rom_rdport_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .wide_sel   (wide_sel),
    .lsb_in     (lsb_in),
    .id_mode    (id_mode),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .data_valid (data_valid)
);

// File: tb/cfg_rom_rdport_tb_top.sv
// Self-checking bench: directed corners plus seeded random traffic, compared
// at each falling edge against a model built from the requirements.
module cfg_rom_rdport_tb_top;
    localparam int ADDR_W  = 6;
    localparam int ACC_CYC = 4;
    localparam int OE_CYC  = 2;
    localparam int DEPTH   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              wide_sel = 1'b1;
    logic              lsb_in = 1'b0;
    logic              id_mode = 1'b0;
    logic              pl_we = 1'b0;
    logic [ADDR_W-1:0] pl_addr = '0;
    logic [15:0]       pl_data = '0;
    logic [15:0]       dq_out;
    logic [15:0]       dq_oe;
    logic              data_valid;

    int compared = 0;
    int mismatched = 0;
    int fage = 0;
    int oage = 0;
    bit finished = 0;
    logic [15:0] shadow [DEPTH];

    always #10 clk = ~clk;

    cfg_rom_rdport #(.ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .wide_sel(wide_sel), .lsb_in(lsb_in), .id_mode(id_mode),
        .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .dq_out(dq_out), .dq_oe(dq_oe), .data_valid(data_valid)
    );

    function automatic logic exp_valid();
        return !ce_n && !oe_n && fage >= ACC_CYC + 1 && oage >= OE_CYC + 1;
    endfunction

    function automatic logic [15:0] exp_oe();
        if (ce_n || oe_n) return 16'h0000;
        return wide_sel ? 16'hFFFF : 16'h00FF;
    endfunction

    function automatic logic [15:0] exp_out();
        logic [15:0] w;
        if (!exp_valid()) return 16'h0000;
        w = shadow[addr];
        if (id_mode)  return {8'h00, (addr[0] ? 8'h32 : 8'h20)};
        if (wide_sel) return w;
        return {8'h00, (lsb_in ? w[15:8] : w[7:0])};
    endfunction

    function automatic string auto_tag();
        if (ce_n || oe_n)  return "R3";
        if (!exp_valid())  return "R6";
        if (id_mode)       return "R5";
        if (wide_sel)      return "R1";
        return "R2";
    endfunction

    // Compare all outputs against the model.
    task automatic compare(input string tag);
        string t;
        t = (tag == "") ? auto_tag() : tag;
        compared++;
        if (dq_out !== exp_out() || dq_oe !== exp_oe() || data_valid !== exp_valid()) begin
            mismatched++;
            $display("FAIL [%s] t=%0t actual out=%h oe=%h v=%b expected out=%h oe=%h v=%b",
                     t, $time, dq_out, dq_oe, data_valid, exp_out(), exp_oe(), exp_valid());
        end
    endtask

    // Advance to the next falling edge, age the windows, then check.
    task automatic tick(input string tag);
        @(negedge clk);
        if (fage < 1000) fage++;
        if (oage < 1000) oage++;
        compare(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    // Drive new read-side inputs and restart the model windows that they touch.
    task automatic drive(input logic [ADDR_W-1:0] a, input logic ce, input logic oe,
                         input logic w, input logic l, input logic id);
        if (a != addr || ce != ce_n || w != wide_sel || id != id_mode ||
            (!w && l != lsb_in)) fage = 0;
        if (oe != oe_n) oage = 0;
        addr = a; ce_n = ce; oe_n = oe; wide_sel = w; lsb_in = l; id_mode = id;
    endtask

    task automatic preload(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        pl_we = 1'b1; pl_addr = a; pl_data = d;
        shadow[a] = d;
        tick("R10");
        pl_we = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < DEPTH; i++) shadow[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick("R3");

        // R4: blank array reads all ones in word mode
        drive(6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(ACC_CYC + 2, "R4");
        drive(6'd63, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(ACC_CYC + 2, "R4");

        // R10: preload while deselected, then read back
        drive(6'd63, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        tick("R3");
        preload(6'd5, 16'hA5C3);
        for (int i = 0; i < 16; i++) preload(6'($urandom % DEPTH), 16'($urandom));
        drive(6'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(ACC_CYC, "R6");      // R6: still waiting on the long window
        ticks(2, "R10");

        // R2: byte select low then high
        drive(6'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        ticks(ACC_CYC + 1, "R2");
        drive(6'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        ticks(ACC_CYC, "R6");
        tick("R2");

        // R7: output enable toggle only uses the short window
        drive(6'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        tick("R3");
        drive(6'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        ticks(OE_CYC, "R7");
        tick("R7");

        // R9: word mode ignores the byte-select bit
        drive(6'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        ticks(ACC_CYC + 1, "R1");
        drive(6'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(2, "R9");

        // R5: identifier codes, upper address bits ignored
        drive(6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        ticks(ACC_CYC + 1, "R5");
        drive(6'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        ticks(ACC_CYC + 1, "R5");
        drive(6'd42, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        ticks(ACC_CYC + 1, "R5");

        // R3: standby floats lanes even with output enable low
        drive(6'd42, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        ticks(2, "R3");

        // Random traffic, biased toward the selected state
        for (int n = 0; n < 400; n++) begin
            logic [ADDR_W-1:0] a;
            logic ce, oe, w, l, id;
            a = addr; ce = ce_n; oe = oe_n; w = wide_sel; l = lsb_in; id = id_mode;
            case ($urandom % 8)
                0, 1, 2: a  = ADDR_W'($urandom % DEPTH);
                3:       ce = ($urandom % 4) == 0;
                4:       oe = ($urandom % 4) == 0;
                5:       w  = !w;
                6:       l  = !l;
                default: id = ($urandom % 3) == 0;
            endcase
            drive(a, ce, oe, w, l, id);
            ticks(1 + ($urandom % 8), "");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL [R6] watchdog expired: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule